// File: doc/BRIEF.md
# Processor Clock Control and Standby Unit

This unit sits between the system oscillator and a small CPU core. It turns the raw oscillator clock into two clock-enable strobes. `cpu_ce` marks one machine-cycle boundary for the core. `per_ce` is a fixed-rate tick for the peripherals. Both are qualified enables; the oscillator clock itself is never gated.

A 4-bit control register drives the unit. Its low pair picks the machine-cycle length: 64, 16, 8 or 4 oscillator periods. Its high pair records standby state: bit 3 for the deep stop mode and bit 2 for the light halt mode. Dedicated request strobes set these standby bits, and a release input clears them. Software can change only the low pair, and a write whose upper pair is nonzero is discarded whole.

All pins are plain control and status signals. The unit has no streaming data path, so it uses no valid/ready handshake. A write is accepted in the same cycle as `wr_en`, and there is no back-pressure.

Top module: `clk_ctrl_unit`

## Requirements
- R1: After reset the register reads 0000 and `cpu_ce` pulses once every 64 oscillator cycles.
- R2: Between consecutive `cpu_ce` pulses there are 64, 16, 8 or 4 cycles for a low pair (bits 1:0) of 00, 01, 10 or 11 respectively.
- R3: A write with `wr_data[3:2]` equal to 00 loads `wr_data[1:0]` into bits 1:0 at the next edge. A write with any other upper pair changes no bit of the register.
- R4: A new divider select only affects the machine cycle that starts after the next `cpu_ce` pulse. The cycle in progress keeps the length it started with, even if the write lands on the boundary cycle itself.
- R5: `stop_req` sets bit 3 and `halt_req` sets bit 2. If both arrive in the same cycle, only bit 3 is set. Requests are ignored while either standby bit is already set or while `wake` is high.
- R6: While bit 2 (halt) is set, `cpu_ce` stays low and `per_ce` keeps pulsing once every 4 cycles.
- R7: While bit 3 (stop) is set, both `cpu_ce` and `per_ce` stay low and both dividers hold their count.
- R8: `wake` clears bits 3 and 2 at the next edge, and the enables then resume. `wake` outside standby leaves the register unchanged.
- R9: `reg_rd` presents {bit3 stop, bit2 halt, bits1:0 select}. `stop_flag` and `halt_flag` mirror bits 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 4 | Register write value |
| stop_req | input | 1 | Request to enter stop mode |
| halt_req | input | 1 | Request to enter halt mode |
| wake | input | 1 | Standby release |
| cpu_ce | output | 1 | CPU machine-cycle enable |
| per_ce | output | 1 | Peripheral clock enable |
| reg_rd | output | 4 | Control register read value |
| stop_flag | output | 1 | Stop mode active |
| halt_flag | output | 1 | Halt mode active |

## Verification
Random select writes land at varying offsets inside a machine cycle, including on the boundary cycle itself. This catches a divider that reloads early or picks up the new select mid-cycle, which would show up as a shortened or stretched gap between `cpu_ce` pulses.

Simultaneous stop and halt requests expose a wrong priority, which would leave halt set and keep the peripherals running. A request arriving during an existing standby exposes a unit that lets one standby mode overwrite the other. Illegal writes with a nonzero upper pair, and a `wake` pulse outside standby, must leave the read value untouched. Counting `per_ce` pulses through halt and stop confirms that only stop silences the peripherals.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Divider select codes held in bits 1:0 of the control register
  typedef enum logic [1:0] {
    SEL_SLOW  = 2'b00,
    SEL_MED   = 2'b01,
    SEL_QUICK = 2'b10,
    SEL_FAST  = 2'b11
  } div_sel_e;

  // Control register layout; bit order is visible to software
  typedef struct packed {
    logic       stop;
    logic       halt;
    logic [1:0] sel;
  } ccr_t;

endpackage

// File: rtl/ccr_core.sv
module ccr_core
  import pcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  input  logic       stop_req,
  input  logic       halt_req,
  input  logic       wake,
  output ccr_t       ccr
);

  logic wr_legal;
  logic idle;

  assign wr_legal = wr_en && (wr_data[3:2] == 2'b00);
  assign idle     = !ccr.stop && !ccr.halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr <= '0;
    end else begin
      if (wr_legal) ccr.sel <= wr_data[1:0];
      if (wake) begin
        ccr.stop <= 1'b0;
        ccr.halt <= 1'b0;
      end else if (idle) begin
        if (stop_req)      ccr.stop <= 1'b1;
        else if (halt_req) ccr.halt <= 1'b1;
      end
    end
  end

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!ccr.stop && !ccr.halt)); // R8

  AST_STOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && halt_req && !wake && idle) |=> (ccr.stop && !ccr.halt)); // R5

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3:2] != 2'b00) |=> (ccr.sel == $past(ccr.sel))); // R3

  AST_SINGLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !(ccr.stop && ccr.halt)); // R5

endmodule

// File: rtl/cyc_div.sv
module cyc_div
  import pcu_pkg::*;
#(
  parameter int FAST_LOG = 2,
  parameter int SLOW_LOG = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int CW = SLOW_LOG;

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] reload_of(input logic [1:0] s);
    case (div_sel_e'(s))
      SEL_FAST:  return CW'((1 << FAST_LOG) - 1);
      SEL_QUICK: return CW'((1 << (FAST_LOG + 1)) - 1);
      SEL_MED:   return CW'((1 << (FAST_LOG + 2)) - 1);
      default:   return CW'((1 << SLOW_LOG) - 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!freeze) begin
      if (cnt == '0)     cnt <= reload_of(sel);
      else               cnt <= cnt - 1'b1;
    end
  end

  assign tick = (cnt == '0);

  AST_NO_EARLY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R4

  AST_CPU_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(cnt)); // R7

endmodule

// File: rtl/per_div.sv
module per_div #(
  parameter int PER_LOG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  output logic tick
);

  logic [PER_LOG-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!freeze) cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);

  AST_PER_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(cnt)); // R7

endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit
  import pcu_pkg::*;
#(
  parameter int FAST_LOG = 2,
  parameter int SLOW_LOG = 6,
  parameter int PER_LOG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  input  logic       stop_req,
  input  logic       halt_req,
  input  logic       wake,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic [3:0] reg_rd,
  output logic       stop_flag,
  output logic       halt_flag
);

  ccr_t ccr;
  logic cpu_tick;
  logic per_tick;

  ccr_core u_ccr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .stop_req (stop_req),
    .halt_req (halt_req),
    .wake     (wake),
    .ccr      (ccr)
  );

  cyc_div #(.FAST_LOG(FAST_LOG), .SLOW_LOG(SLOW_LOG)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (ccr.stop),
    .sel    (ccr.sel),
    .tick   (cpu_tick)
  );

  per_div #(.PER_LOG(PER_LOG)) u_per (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (ccr.stop),
    .tick   (per_tick)
  );

  assign cpu_ce    = cpu_tick && !ccr.stop && !ccr.halt;
  assign per_ce    = per_tick && !ccr.stop;
  assign reg_rd    = ccr;
  assign stop_flag = ccr.stop;
  assign halt_flag = ccr.halt;

endmodule

// File: tb/tb_clk_ctrl_unit.sv
`timescale 1ns/1ps
module tb_clk_ctrl_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic       stop_req = 1'b0;
  logic       halt_req = 1'b0;
  logic       wake = 1'b0;
  logic       cpu_ce, per_ce, stop_flag, halt_flag;
  logic [3:0] reg_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  clk_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stop_req(stop_req), .halt_req(halt_req), .wake(wake),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .reg_rd(reg_rd),
    .stop_flag(stop_flag), .halt_flag(halt_flag)
  );

  function automatic int period_of(input logic [1:0] s);
    case (s)
      2'b00:   return 64;
      2'b01:   return 16;
      2'b10:   return 8;
      default: return 4;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Advance (possibly zero steps) to a negedge where cpu_ce is high
  task automatic find_pulse(output int waited);
    waited = 0;
    while (!cpu_ce && waited < 300) begin
      @(negedge clk); waited++;
    end
  endtask

  // From a pulse negedge, count to the next pulse; optionally write at step 'at'
  task automatic gap_write(input int at, input bit do_wr, input logic [3:0] d, output int g);
    g = 0;
    do begin
      if (do_wr && g == at) begin wr_en = 1'b1; wr_data = d; end
      @(negedge clk);
      wr_en = 1'b0;
      g++;
    end while (!cpu_ce && g < 300);
  endtask

  task automatic pulse_in(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int g, w, ncpu, nper;
    logic [1:0] cur;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset value and slow mode
    check(reg_rd == 4'b0000, "R1 reset value", reg_rd, 0);
    check(!stop_flag && !halt_flag, "R9 flags at reset", {stop_flag, halt_flag}, 0);
    find_pulse(w);
    gap_write(0, 1'b0, 4'h0, g);
    check(g == 64, "R1 reset period", g, 64);

    // R2: each code directed
    for (int c = 3; c >= 0; c--) begin
      wr(4'(c));
      check(reg_rd == 4'(c), "R3 legal write", reg_rd, c);
      find_pulse(w);
      gap_write(0, 1'b0, 4'h0, g);
      check(g == period_of(2'(c)), "R2 period per code", g, period_of(2'(c)));
    end
    cur = 2'b00;

    // R4: write on the boundary cycle keeps the old length
    wr(4'b0011); cur = 2'b11;
    find_pulse(w);
    gap_write(0, 1'b0, 4'h0, g);
    gap_write(0, 1'b1, 4'b0000, g);
    check(g == 4, "R4 boundary write keeps old cycle", g, 4);
    gap_write(0, 1'b0, 4'h0, g);
    check(g == 64, "R4 new select after boundary", g, 64);
    // R4: write mid-cycle
    gap_write(10, 1'b1, 4'b0011, g);
    check(g == 64, "R4 mid-cycle write keeps length", g, 64);
    gap_write(0, 1'b0, 4'h0, g);
    check(g == 4, "R4 mid-cycle write then applies", g, 4);
    cur = 2'b11;

    // Random: legal and illegal writes at varying offsets
    for (int i = 0; i < 24; i++) begin
      logic [3:0] d;
      int at;
      d  = 4'($urandom % 16);
      if (($urandom % 3) != 0) d[3:2] = 2'b00;
      at = int'($urandom % 4);
      gap_write(at, 1'b1, d, g);
      check(g == period_of(cur), "R4 random cycle length", g, period_of(cur));
      if (d[3:2] == 2'b00) cur = d[1:0];
      check(reg_rd == {2'b00, cur}, "R3 random write result", reg_rd, {2'b00, cur});
    end

    // R6: halt
    wr(4'b0001); cur = 2'b01;
    pulse_in(halt_req);
    check(halt_flag && reg_rd == 4'b0101, "R5 halt sets bit 2", reg_rd, 5);
    pulse_in(stop_req);
    check(reg_rd == 4'b0101, "R5 stop ignored during halt", reg_rd, 5);
    ncpu = 0; nper = 0;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      if (cpu_ce) ncpu++;
      if (per_ce) nper++;
    end
    check(ncpu == 0, "R6 cpu_ce low in halt", ncpu, 0);
    check(nper == 32, "R6 per_ce keeps running in halt", nper, 32);
    // R8: wake
    pulse_in(wake);
    check(reg_rd == 4'b0001 && !halt_flag, "R8 wake clears halt", reg_rd, 1);
    find_pulse(w);
    check(w <= 16, "R8 cpu_ce resumes after halt", w, 16);
    gap_write(0, 1'b0, 4'h0, g);
    check(g == 16, "R2 period after wake", g, 16);

    // R7: stop, with simultaneous halt request
    @(negedge clk); stop_req = 1'b1; halt_req = 1'b1;
    @(negedge clk); stop_req = 1'b0; halt_req = 1'b0;
    check(reg_rd == 4'b1001 && stop_flag && !halt_flag, "R5 stop wins over halt", reg_rd, 9);
    ncpu = 0; nper = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (cpu_ce) ncpu++;
      if (per_ce) nper++;
    end
    check(ncpu == 0, "R7 cpu_ce low in stop", ncpu, 0);
    check(nper == 0, "R7 per_ce low in stop", nper, 0);
    pulse_in(wake);
    check(reg_rd == 4'b0001 && !stop_flag, "R8 wake clears stop", reg_rd, 1);
    nper = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (per_ce) nper++;
    end
    check(nper == 4, "R8 per_ce resumes after stop", nper, 4);
    find_pulse(w);
    gap_write(0, 1'b0, 4'h0, g);
    check(g == 16, "R8 cpu period after stop", g, 16);

    // R8: wake outside standby, and request blocked by wake
    pulse_in(wake);
    check(reg_rd == 4'b0001, "R8 idle wake no effect", reg_rd, 1);
    @(negedge clk); wake = 1'b1; halt_req = 1'b1;
    @(negedge clk); wake = 1'b0; halt_req = 1'b0;
    check(reg_rd == 4'b0001, "R5 request ignored with wake", reg_rd, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule